// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block forms linear addresses for a processor core that keeps the segmented memory model of early personal computers. It owns six 16-bit segment registers (code, data, stack and three auxiliary) and the instruction pointer, and both come out of reset already pointing at the first instruction fetch. Each access names a kind (instruction fetch, data, stack, or an explicitly chosen segment) and an offset. The block returns the linear address one clock later.

The translation rule depends on the operating mode. In real mode the segment value is shifted left by four bits and the 16-bit offset is added, wrapping inside a 20-bit space. In protected mode a segment register write also captures a descriptor (base, limit, flags) into a shadow for that register. The descriptor comes from an external lookup port indexed by the selector. Accesses then add the shadow base to the offset and raise a fault when the offset passes the limit. In the 64-bit flat mode segmentation is bypassed and the offset is the linear address. Loading descriptor tables from memory, privilege checks and paging belong to other blocks.

Top module: `seg_xlate`

## Requirements
- R1: After reset the code segment holds 0xF000, the instruction pointer 0xFFF0 and every other segment 0. A real-mode fetch issued straight after reset yields linear address 0xFFFF0.
- R2: In real mode (mode 2'b00) the linear address is (segment << 4) + offset[15:0], zero-extended. Offset bits above 15 have no effect.
- R3: The real-mode sum is kept to 20 bits and any carry out of bit 19 is dropped, so segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R4: The access kind selects the segment: 0 fetch uses the code segment with the instruction pointer as offset, 1 uses data, 2 uses stack, and 3 uses the register numbered by the segment index input. The indices are 0 code, 1 data, 2 stack, and 3 to 5 for the auxiliary segments.
- R5: The descriptor index output equals bits [15:3] of the selector being written. A register write in protected mode (mode 2'b01) captures base, limit and flags into that register's shadow. A write in any other mode leaves the shadow unchanged.
- R6: In protected mode the linear address is shadow base + offset, modulo 2^OFF_W. The flags output returns the shadow flags of the segment used.
- R7: In protected mode an offset greater than the shadow limit sets the fault output and clears the valid output. An offset equal to the limit is valid. Valid and fault are never both high.
- R8: In flat mode (mode 2'b10 or 2'b11) the linear address equals the offset, with no limit check.
- R9: Results appear in the cycle after the access request. In a cycle with no request, valid and fault are both low one cycle later.
- R10: An explicit access with segment index 6 or 7 raises the fault output in every mode.
- R11: An instruction pointer write takes effect on the next clock edge, and later fetches use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 real, 01 protected, 1x flat |
| wr_en_i | input | 1 | Segment register write strobe |
| wr_seg_i | input | 3 | Segment register index to write |
| wr_sel_i | input | SEL_W | Selector or real-mode segment value |
| desc_idx_o | output | SEL_W-3 | Descriptor table index for lookup |
| desc_base_i | input | OFF_W | Looked-up descriptor base |
| desc_limit_i | input | OFF_W | Looked-up descriptor limit |
| desc_flags_i | input | FLAG_W | Looked-up descriptor flags |
| ip_wr_en_i | input | 1 | Instruction pointer write strobe |
| ip_wr_i | input | OFF_W | New instruction pointer |
| ip_o | output | OFF_W | Current instruction pointer |
| acc_valid_i | input | 1 | Access request |
| acc_kind_i | input | 2 | Access kind (fetch, data, stack, explicit) |
| acc_seg_i | input | 3 | Segment index for explicit accesses |
| acc_off_i | input | OFF_W | Access offset |
| lin_valid_o | output | 1 | Linear address valid |
| fault_o | output | 1 | Limit or segment-index fault |
| lin_addr_o | output | OFF_W | Linear address |
| seg_flags_o | output | FLAG_W | Flags of the segment used |

## Verification
The bench uses the default parameters: 32-bit offsets, 16-bit selectors and 4-bit flags. With these defaults the protected-mode base sum can wrap past 2^32. The bench also drives real-mode offsets with their upper 16 bits set, so it can show that those bits are discarded. The 20-bit real-mode wrap is reached through segment 0xFFFF. The limit check is probed exactly at the limit and one past it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam logic [1:0] MODE_REAL = 2'b00;
  localparam logic [1:0] MODE_PROT = 2'b01;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_DATA  = 2'd1;
  localparam logic [1:0] KIND_STACK = 2'd2;
  localparam logic [1:0] KIND_EXPL  = 2'd3;

  localparam int SEG_CODE  = 0;
  localparam int SEG_DATA  = 1;
  localparam int SEG_STACK = 2;

  localparam logic [15:0] CS_AT_RESET = 16'hF000;
  localparam logic [15:0] IP_AT_RESET = 16'hFFF0;
  localparam int          REAL_SHIFT  = 4;
endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 32,
  parameter int FLAG_W = 4,
  parameter int NSEG   = 6,
  parameter int IDX_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_seg,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic                         load_desc,
  input  logic [OFF_W-1:0]             desc_base,
  input  logic [OFF_W-1:0]             desc_limit,
  input  logic [FLAG_W-1:0]            desc_flags,
  input  logic                         ip_wr_en,
  input  logic [OFF_W-1:0]             ip_wr,
  output logic [NSEG-1:0][SEL_W-1:0]   sel_q,
  output logic [NSEG-1:0][OFF_W-1:0]   base_q,
  output logic [NSEG-1:0][OFF_W-1:0]   limit_q,
  output logic [NSEG-1:0][FLAG_W-1:0]  flags_q,
  output logic [OFF_W-1:0]             ip_q
);
  localparam logic [OFF_W-1:0] LIMIT_RST = OFF_W'({SEL_W{1'b1}});

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [SEL_W-1:0] SEL_RST = (g == SEG_CODE) ? SEL_W'(CS_AT_RESET) : '0;
    logic             hit, cap;
    logic [SEL_W-1:0] sel_d;

    always_comb begin
      hit   = wr_en && (wr_seg == IDX_W'(g));
      cap   = hit && load_desc;
      sel_d = hit ? wr_sel : sel_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g]   <= SEL_RST;
        base_q[g]  <= '0;
        limit_q[g] <= LIMIT_RST;
        flags_q[g] <= '0;
      end else begin
        sel_q[g] <= sel_d;
        if (cap) begin
          base_q[g]  <= desc_base;
          limit_q[g] <= desc_limit;
          flags_q[g] <= desc_flags;
        end
      end
    end
  end

  logic [OFF_W-1:0] ip_d;
  always_comb ip_d = ip_wr_en ? ip_wr : ip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= OFF_W'(IP_AT_RESET);
    else        ip_q <= ip_d;
  end
endmodule

// File: rtl/seg_xlate_pick.sv
module seg_xlate_pick
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 32,
  parameter int FLAG_W = 4,
  parameter int NSEG   = 6,
  parameter int IDX_W  = 3
) (
  input  logic [1:0]                   kind,
  input  logic [IDX_W-1:0]             seg_idx,
  input  logic [OFF_W-1:0]             acc_off,
  input  logic [OFF_W-1:0]             ip_q,
  input  logic [NSEG-1:0][SEL_W-1:0]   sel_q,
  input  logic [NSEG-1:0][OFF_W-1:0]   base_q,
  input  logic [NSEG-1:0][OFF_W-1:0]   limit_q,
  input  logic [NSEG-1:0][FLAG_W-1:0]  flags_q,
  output logic                         idx_ok,
  output logic [SEL_W-1:0]             sel,
  output logic [OFF_W-1:0]             base,
  output logic [OFF_W-1:0]             limit,
  output logic [FLAG_W-1:0]            flags,
  output logic [OFF_W-1:0]             off
);
  logic [IDX_W-1:0] pick, safe;

  always_comb begin
    unique case (kind)
      KIND_FETCH: pick = IDX_W'(SEG_CODE);
      KIND_DATA:  pick = IDX_W'(SEG_DATA);
      KIND_STACK: pick = IDX_W'(SEG_STACK);
      default:    pick = seg_idx;
    endcase
    idx_ok = (pick < IDX_W'(NSEG));
    safe   = idx_ok ? pick : '0;
    sel    = sel_q[safe];
    base   = base_q[safe];
    limit  = limit_q[safe];
    flags  = flags_q[safe];
    off    = (kind == KIND_FETCH) ? ip_q : acc_off;
  end
endmodule

// File: rtl/seg_xlate_calc.sv
module seg_xlate_calc
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int OFF_W = 32
) (
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [OFF_W-1:0] base,
  input  logic [OFF_W-1:0] limit,
  input  logic [OFF_W-1:0] off,
  output logic [OFF_W-1:0] addr,
  output logic             over
);
  localparam int REAL_W = SEL_W + REAL_SHIFT;

  logic [REAL_W-1:0] real_sum;

  always_comb begin
    real_sum = {sel, {REAL_SHIFT{1'b0}}} + {{REAL_SHIFT{1'b0}}, off[SEL_W-1:0]};
    over     = 1'b0;
    if (mode == MODE_REAL) begin
      addr = OFF_W'(real_sum);
    end else if (mode == MODE_PROT) begin
      addr = base + off;
      over = (off > limit);
    end else begin
      addr = off;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 32,
  parameter int FLAG_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_seg_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  output logic [SEL_W-4:0]   desc_idx_o,
  input  logic [OFF_W-1:0]   desc_base_i,
  input  logic [OFF_W-1:0]   desc_limit_i,
  input  logic [FLAG_W-1:0]  desc_flags_i,
  input  logic               ip_wr_en_i,
  input  logic [OFF_W-1:0]   ip_wr_i,
  output logic [OFF_W-1:0]   ip_o,
  input  logic               acc_valid_i,
  input  logic [1:0]         acc_kind_i,
  input  logic [2:0]         acc_seg_i,
  input  logic [OFF_W-1:0]   acc_off_i,
  output logic               lin_valid_o,
  output logic               fault_o,
  output logic [OFF_W-1:0]   lin_addr_o,
  output logic [FLAG_W-1:0]  seg_flags_o
);
  localparam int NSEG  = 6;
  localparam int IDX_W = 3;

  logic [NSEG-1:0][SEL_W-1:0]  sel_q;
  logic [NSEG-1:0][OFF_W-1:0]  base_q, limit_q;
  logic [NSEG-1:0][FLAG_W-1:0] flags_q;
  logic [OFF_W-1:0]            ip_q;

  assign desc_idx_o = wr_sel_i[SEL_W-1:3];
  assign ip_o       = ip_q;

  seg_xlate_regs #(.SEL_W(SEL_W), .OFF_W(OFF_W), .FLAG_W(FLAG_W),
                   .NSEG(NSEG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wr_seg(wr_seg_i), .wr_sel(wr_sel_i),
    .load_desc(mode_i == MODE_PROT),
    .desc_base(desc_base_i), .desc_limit(desc_limit_i), .desc_flags(desc_flags_i),
    .ip_wr_en(ip_wr_en_i), .ip_wr(ip_wr_i),
    .sel_q(sel_q), .base_q(base_q), .limit_q(limit_q), .flags_q(flags_q),
    .ip_q(ip_q)
  );

  logic              idx_ok, over;
  logic [SEL_W-1:0]  p_sel;
  logic [OFF_W-1:0]  p_base, p_limit, p_off, addr;
  logic [FLAG_W-1:0] p_flags;

  seg_xlate_pick #(.SEL_W(SEL_W), .OFF_W(OFF_W), .FLAG_W(FLAG_W),
                   .NSEG(NSEG), .IDX_W(IDX_W)) u_pick (
    .kind(acc_kind_i), .seg_idx(acc_seg_i), .acc_off(acc_off_i), .ip_q(ip_q),
    .sel_q(sel_q), .base_q(base_q), .limit_q(limit_q), .flags_q(flags_q),
    .idx_ok(idx_ok), .sel(p_sel), .base(p_base), .limit(p_limit),
    .flags(p_flags), .off(p_off)
  );

  seg_xlate_calc #(.SEL_W(SEL_W), .OFF_W(OFF_W)) u_calc (
    .mode(mode_i), .sel(p_sel), .base(p_base), .limit(p_limit),
    .off(p_off), .addr(addr), .over(over)
  );

  logic              valid_d, fault_d;
  logic [OFF_W-1:0]  addr_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    valid_d = acc_valid_i && idx_ok && !over;
    fault_d = acc_valid_i && (!idx_ok || over);
    addr_d  = acc_valid_i ? addr    : lin_addr_o;
    flags_d = acc_valid_i ? p_flags : seg_flags_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_valid_o <= 1'b0;
      fault_o     <= 1'b0;
      lin_addr_o  <= '0;
      seg_flags_o <= '0;
    end else begin
      lin_valid_o <= valid_d;
      fault_o     <= fault_d;
      lin_addr_o  <= addr_d;
      seg_flags_o <= flags_d;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             acc_valid_i,
  input logic [1:0]       acc_kind_i,
  input logic [2:0]       acc_seg_i,
  input logic [OFF_W-1:0] acc_off_i,
  input logic             lin_valid_o,
  input logic             fault_o,
  input logic [OFF_W-1:0] lin_addr_o
);
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lin_valid_o && fault_o));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> (!lin_valid_o && !fault_o));

  // R8
  flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && mode_i[1] && (acc_kind_i == KIND_DATA || acc_kind_i == KIND_STACK))
    |=> (lin_valid_o && lin_addr_o == $past(acc_off_i)));

  // R2
  real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && mode_i == MODE_REAL && acc_kind_i != KIND_EXPL)
    |=> (lin_valid_o && (lin_addr_o >> 20) == '0));

  // R10
  badseg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_kind_i == KIND_EXPL && acc_seg_i >= 3'd6)
    |=> (fault_o && !lin_valid_o));
endmodule

bind seg_xlate seg_xlate_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .acc_valid_i(acc_valid_i),
  .acc_kind_i(acc_kind_i), .acc_seg_i(acc_seg_i), .acc_off_i(acc_off_i),
  .lin_valid_o(lin_valid_o), .fault_o(fault_o), .lin_addr_o(lin_addr_o)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  localparam int SEL_W = 16, OFF_W = 32, FLAG_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        mode_i;
  logic              wr_en_i;
  logic [2:0]        wr_seg_i;
  logic [SEL_W-1:0]  wr_sel_i;
  logic [SEL_W-4:0]  desc_idx_o;
  logic [OFF_W-1:0]  desc_base_i, desc_limit_i;
  logic [FLAG_W-1:0] desc_flags_i;
  logic              ip_wr_en_i;
  logic [OFF_W-1:0]  ip_wr_i, ip_o;
  logic              acc_valid_i;
  logic [1:0]        acc_kind_i;
  logic [2:0]        acc_seg_i;
  logic [OFF_W-1:0]  acc_off_i;
  logic              lin_valid_o, fault_o;
  logic [OFF_W-1:0]  lin_addr_o;
  logic [FLAG_W-1:0] seg_flags_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  seg_xlate #(.SEL_W(SEL_W), .OFF_W(OFF_W), .FLAG_W(FLAG_W)) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [2:0] idx, input logic [15:0] sel,
                        input logic [31:0] b, input logic [31:0] l, input logic [3:0] f);
    @(negedge clk);
    wr_en_i = 1; wr_seg_i = idx; wr_sel_i = sel;
    desc_base_i = b; desc_limit_i = l; desc_flags_i = f;
    #1 check("R5 desc index", desc_idx_o, sel >> 3);
    @(negedge clk);
    wr_en_i = 0;
  endtask

  // Issues one access; results sampled on the following falling edge.
  task automatic access(input logic [1:0] kind, input logic [2:0] seg, input logic [31:0] off);
    @(negedge clk);
    acc_valid_i = 1; acc_kind_i = kind; acc_seg_i = seg; acc_off_i = off;
    @(negedge clk);
    acc_valid_i = 0;
  endtask

  task automatic expect_ok(string req, logic [31:0] addr);
    check(req, {lin_valid_o, fault_o}, 2'b10);
    check(req, lin_addr_o, addr);
  endtask

  task automatic t_reset;
    check("R1 ip", ip_o, 32'hFFF0);
    check("R9 idle", {lin_valid_o, fault_o}, 2'b00);
    access(2'd0, 3'd0, 32'h0);
    expect_ok("R1 first fetch", 32'hFFFF0);
    access(2'd1, 3'd0, 32'h1234);
    expect_ok("R1 data seg zero", 32'h01234);
  endtask

  task automatic t_real;
    mode_i = 2'b00;
    wr_seg(3'd1, 16'h1234, 32'h5555_0000, 32'h0, 4'h0);
    access(2'd1, 3'd0, 32'h0010);
    expect_ok("R2 real", 32'h12350);
    access(2'd1, 3'd0, 32'hABCD_0010);
    expect_ok("R2 upper offset ignored", 32'h12350);
    wr_seg(3'd2, 16'hFFFF, 32'h0, 32'h0, 4'h0);
    access(2'd2, 3'd0, 32'hFFFF);
    expect_ok("R3 wrap", 32'h0FFEF);
    wr_seg(3'd4, 16'h2000, 32'h0, 32'h0, 4'h0);
    access(2'd3, 3'd4, 32'h5);
    expect_ok("R4 explicit aux", 32'h20005);
    access(2'd3, 3'd6, 32'h5);
    check("R10 bad index", {lin_valid_o, fault_o}, 2'b01);
    @(negedge clk);
    check("R9 idle after", {lin_valid_o, fault_o}, 2'b00);
  endtask

  task automatic t_ip;
    @(negedge clk);
    ip_wr_en_i = 1; ip_wr_i = 32'h1234;
    @(negedge clk);
    ip_wr_en_i = 0;
    check("R11 ip", ip_o, 32'h1234);
    access(2'd0, 3'd0, 32'hFFFF);
    expect_ok("R11 fetch uses ip", 32'hF1234);
  endtask

  task automatic t_prot;
    mode_i = 2'b01;
    wr_seg(3'd1, 16'h0023, 32'h0010_0000, 32'h0000_0FFF, 4'hA);
    access(2'd1, 3'd0, 32'h100);
    expect_ok("R6 base plus offset", 32'h0010_0100);
    check("R6 flags", seg_flags_o, 4'hA);
    access(2'd1, 3'd0, 32'hFFF);
    expect_ok("R7 at limit", 32'h0010_0FFF);
    access(2'd1, 3'd0, 32'h1000);
    check("R7 past limit", {lin_valid_o, fault_o}, 2'b01);
    // stack shadow was never loaded (written in real mode only)
    access(2'd2, 3'd0, 32'h10);
    expect_ok("R5 real write kept shadow", 32'h10);
    wr_seg(3'd3, 16'h0018, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 4'h3);
    access(2'd3, 3'd3, 32'h20);
    expect_ok("R6 base wrap", 32'h0000_0010);
    access(2'd3, 3'd7, 32'h0);
    check("R10 bad index prot", {lin_valid_o, fault_o}, 2'b01);
  endtask

  task automatic t_flat;
    mode_i = 2'b10;
    access(2'd1, 3'd0, 32'hDEAD_BEEF);
    expect_ok("R8 flat", 32'hDEAD_BEEF);
    mode_i = 2'b11;
    access(2'd3, 3'd3, 32'h0000_0040);
    expect_ok("R8 flat alt", 32'h0000_0040);
    access(2'd3, 3'd6, 32'h0);
    check("R10 bad index flat", {lin_valid_o, fault_o}, 2'b01);
  endtask

  initial begin
    rst_n = 0; mode_i = 0; wr_en_i = 0; wr_seg_i = 0; wr_sel_i = 0;
    desc_base_i = 0; desc_limit_i = 0; desc_flags_i = 0;
    ip_wr_en_i = 0; ip_wr_i = 0; acc_valid_i = 0; acc_kind_i = 0;
    acc_seg_i = 0; acc_off_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_real();
    t_ip();
    t_prot();
    t_flat();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule